// File: doc/BRIEF.md
# LL/SC Local Reservation Register

This block sits on the cache side of one processor and keeps that processor's load-linked / store-conditional reservation. Registration happens in two phases. When the processor issues a load-linked (LL) command, the block stores the target address and the reservation becomes pending. Later the memory side answers the LL and returns a key that it allocated for the reservation. The block stores that key, and the reservation is then held.

When the processor issues a store-conditional (SC), the block decides whether the SC may leave the cache. If a reservation is held and the SC address equals the stored address, the block raises a one-cycle go pulse and presents the stored key, which travels with the outgoing SC command so that the memory side can check that the reservation is still valid. In every other case the SC fails locally and is not sent. Any SC ends the reservation, whatever its outcome. A flush input drops the reservation at once. Bus transport is not part of this block.

The control is a three-state machine. RS_IDLE means no reservation. RS_PEND means an LL was issued and its response is awaited. RS_HELD means the key has arrived. The transitions are named as follows. LL_START leads from any state to RS_PEND on an LL issue. KEY_ARRIVE leads from RS_PEND to RS_HELD on an accepted response. SC_CONSUME leads from any state to RS_IDLE on an SC issue. FLUSH_DROP leads from any state to RS_IDLE on a flush. In every other case the state is held. When several of these events fall in the same cycle, the priority is FLUSH_DROP, then LL_START, then SC_CONSUME, then KEY_ARRIVE.

Top module: `llsc_resv_unit`

## Requirements
- R1: After reset, resv_valid_o, sc_go_o and sc_lfail_o are all 0.
- R2: An LL issue stores ll_addr_i as the reservation address and makes the reservation pending. resv_valid_o reads 0 from the next cycle until a response is accepted, and an SC made while the reservation is only pending fails locally.
- R3: An LL response that arrives while the reservation is pending stores ll_key_i. resv_valid_o is 1 from the following cycle.
- R4: An SC issued while a reservation is held, with sc_addr_i equal to the stored address, gives sc_go_o=1 and sc_lfail_o=0 in the next cycle, with sc_key_o equal to the stored key.
- R5: Every SC consumes the reservation. resv_valid_o is 0 in the cycle after it, and a second SC to the same address fails locally.
- R6: An SC whose address differs from the stored address, or that finds no held reservation, gives sc_lfail_o=1 and sc_go_o=0 in the next cycle. Every SC issue produces exactly one of go or fail.
- R7: An LL response that arrives with no pending LL (state idle or held) is ignored. The valid flag and the stored key stay as they were.
- R8: A new LL issue replaces any earlier reservation. The old address no longer matches, and the key from the new response is used.
- R9: A flush clears the reservation in one cycle. An SC issued in the same cycle as a flush fails locally.
- R10: An SC issued in the same cycle as an LL issue is judged against the reservation held before that cycle. Afterwards the new reservation is pending.
- R11: An SC issued in the same cycle as the response to a pending LL fails locally, and that response is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_issue_i | input | 1 | LL command issued this cycle |
| ll_addr_i | input | ADDR_W | Address of the LL command |
| ll_rsp_i | input | 1 | LL response arrives this cycle |
| ll_key_i | input | KEY_W | Key carried by the LL response |
| sc_issue_i | input | 1 | SC issued this cycle |
| sc_addr_i | input | ADDR_W | Address of the SC |
| flush_i | input | 1 | Drop the reservation |
| resv_valid_o | output | 1 | A reservation is held (key stored) |
| sc_go_o | output | 1 | One-cycle pulse: the SC may be sent |
| sc_key_o | output | KEY_W | Stored key, meaningful while sc_go_o is 1 |
| sc_lfail_o | output | 1 | One-cycle pulse: the SC failed locally |

## Verification
The SC judgement and the LL registration can meet in the same cycle in two ways. An SC can land in the cycle of a new LL issue, and an SC can land in the cycle of the response that would complete a pending LL. The bench provokes both on purpose with directed sequences. Random traffic over a small address set also raises them often. For each such collision, a reference model in the bench computes the go or fail pulse from the state held before the cycle and the state that follows. The bench then checks the outcome later through a further SC and its key.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Reservation progress of the local LL/SC register
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_PEND = 2'd1,
        RS_HELD = 2'd2
    } resv_state_e;

endpackage

// File: rtl/llsc_resv_store.sv
module llsc_resv_store #(
    parameter int ADDR_W = 32,
    parameter int KEY_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              load_key_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              addr_hit_o,
    output logic [KEY_W-1:0]  key_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [KEY_W-1:0]  key_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_addr_i) begin
            addr_q <= addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (load_key_i) begin
            key_q <= key_i;
        end
    end

    always_comb begin
        addr_hit_o = (addr_q == probe_addr_i);
        key_o      = key_q;
    end

    // R7: the key register changes only on an accepted response
    a_r7_key_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !load_key_i |=> $stable(key_o));

endmodule

// File: rtl/llsc_resv_fsm.sv
module llsc_resv_fsm
    import llsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush_i,
    input  logic        ll_issue_i,
    input  logic        ll_rsp_i,
    input  logic        sc_issue_i,
    input  logic        addr_hit_i,
    output resv_state_e state_o,
    output logic        take_rsp_o,
    output logic        sc_pass_o,
    output logic        sc_reject_o
);

    resv_state_e state_q;
    resv_state_e state_d;
    logic        rsp_fits;

    // Which response may complete the registration
    always_comb begin
        rsp_fits = 1'b0;
        unique case (state_q)
            RS_IDLE: rsp_fits = 1'b0;
            RS_PEND: rsp_fits = ll_rsp_i;
            RS_HELD: rsp_fits = 1'b0;
            default: rsp_fits = 1'b0;
        endcase
    end

    // Transition choice: flush, then LL, then SC, then response
    always_comb begin
        state_d = state_q;
        if (flush_i) begin
            state_d = RS_IDLE;              // FLUSH_DROP
        end else if (ll_issue_i) begin
            state_d = RS_PEND;              // LL_START
        end else if (sc_issue_i) begin
            state_d = RS_IDLE;              // SC_CONSUME
        end else if (rsp_fits) begin
            state_d = RS_HELD;              // KEY_ARRIVE
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and strobes
    always_comb begin
        state_o     = state_q;
        take_rsp_o  = rsp_fits && !flush_i && !ll_issue_i && !sc_issue_i;
        sc_pass_o   = 1'b0;
        sc_reject_o = 1'b0;
        if (sc_issue_i) begin
            unique case (state_q)
                RS_HELD: begin
                    sc_pass_o   = addr_hit_i && !flush_i;
                    sc_reject_o = !(addr_hit_i && !flush_i);
                end
                RS_IDLE, RS_PEND: sc_reject_o = 1'b1;
                default:          sc_reject_o = 1'b1;
            endcase
        end
    end

    // R9: a flush always leaves the machine idle
    a_r9_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> state_q == RS_IDLE);
    // R2 / R8: an LL without flush always restarts registration
    a_r8_ll_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_issue_i && !flush_i) |=> state_q == RS_PEND);
    // R5: an SC without LL leaves no reservation
    a_r5_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_issue_i && !ll_issue_i) |=> state_q == RS_IDLE);
    // R3: the held state is only entered from the pending state
    a_r3_held_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HELD && $past(state_q) != RS_HELD) |-> $past(state_q) == RS_PEND);

endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge #(
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sc_pass_i,
    input  logic             sc_reject_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             sc_go_o,
    output logic             sc_lfail_o,
    output logic [KEY_W-1:0] sc_key_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_go_o    <= 1'b0;
            sc_lfail_o <= 1'b0;
            sc_key_o   <= '0;
        end else begin
            sc_go_o    <= sc_pass_i;
            sc_lfail_o <= sc_reject_i;
            sc_key_o   <= sc_pass_i ? key_i : '0;
        end
    end

    // R6: go and fail never appear together
    a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sc_go_o, sc_lfail_o}));

endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KEY_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_issue_i,
    input  logic [ADDR_W-1:0] ll_addr_i,
    input  logic              ll_rsp_i,
    input  logic [KEY_W-1:0]  ll_key_i,
    input  logic              sc_issue_i,
    input  logic [ADDR_W-1:0] sc_addr_i,
    input  logic              flush_i,
    output logic              resv_valid_o,
    output logic              sc_go_o,
    output logic [KEY_W-1:0]  sc_key_o,
    output logic              sc_lfail_o
);

    resv_state_e       state;
    logic              take_rsp;
    logic              sc_pass;
    logic              sc_reject;
    logic              addr_hit;
    logic              load_addr;
    logic [KEY_W-1:0]  stored_key;

    assign load_addr = ll_issue_i && !flush_i;

    llsc_resv_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .ll_issue_i  (ll_issue_i),
        .ll_rsp_i    (ll_rsp_i),
        .sc_issue_i  (sc_issue_i),
        .addr_hit_i  (addr_hit),
        .state_o     (state),
        .take_rsp_o  (take_rsp),
        .sc_pass_o   (sc_pass),
        .sc_reject_o (sc_reject)
    );

    llsc_resv_store #(
        .ADDR_W (ADDR_W),
        .KEY_W  (KEY_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_addr_i  (load_addr),
        .addr_i       (ll_addr_i),
        .load_key_i   (take_rsp),
        .key_i        (ll_key_i),
        .probe_addr_i (sc_addr_i),
        .addr_hit_o   (addr_hit),
        .key_o        (stored_key)
    );

    llsc_sc_judge #(
        .KEY_W (KEY_W)
    ) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sc_pass_i   (sc_pass),
        .sc_reject_i (sc_reject),
        .key_i       (stored_key),
        .sc_go_o     (sc_go_o),
        .sc_lfail_o  (sc_lfail_o),
        .sc_key_o    (sc_key_o)
    );

    assign resv_valid_o = (state == RS_HELD);

    // R6: every SC issue yields a verdict in the next cycle
    a_r6_sc_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        sc_issue_i |=> (sc_go_o || sc_lfail_o));
    // R4: go requires a reservation held in the issuing cycle
    a_r4_go_needs_held: assert property (@(posedge clk) disable iff (!rst_n)
        sc_go_o |-> $past(resv_valid_o));
    // R9: flush blocks go and clears the valid flag
    a_r9_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!resv_valid_o && !sc_go_o));
    // R11: SC together with a response never yields a held reservation
    a_r11_sc_beats_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_issue_i && ll_rsp_i && !ll_issue_i) |=> !resv_valid_o);

endmodule

// File: tb/llsc_resv_unit_test.sv
`timescale 1ns/1ps
module llsc_resv_unit_test;

    localparam int AW = 32;
    localparam int KW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_issue = 1'b0;
    logic [AW-1:0] ll_addr = '0;
    logic          ll_rsp = 1'b0;
    logic [KW-1:0] ll_key = '0;
    logic          sc_issue = 1'b0;
    logic [AW-1:0] sc_addr = '0;
    logic          flush = 1'b0;
    logic          resv_valid;
    logic          sc_go;
    logic [KW-1:0] sc_key;
    logic          sc_lfail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model: 0 idle, 1 pending, 2 held
    int          m_st = 0;
    logic [AW-1:0] m_addr = '0;
    logic [KW-1:0] m_key = '0;

    always #2.5 clk = ~clk;

    llsc_resv_unit #(.ADDR_W(AW), .KEY_W(KW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ll_issue_i   (ll_issue),
        .ll_addr_i    (ll_addr),
        .ll_rsp_i     (ll_rsp),
        .ll_key_i     (ll_key),
        .sc_issue_i   (sc_issue),
        .sc_addr_i    (sc_addr),
        .flush_i      (flush),
        .resv_valid_o (resv_valid),
        .sc_go_o      (sc_go),
        .sc_key_o     (sc_key),
        .sc_lfail_o   (sc_lfail)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string pick_tag(bit l, bit r, bit s, bit f, bit go);
        if (f)                 return "R9";
        if (l && s)            return "R10";
        if (s && r && m_st==1) return "R11";
        if (s && go)           return "R4";
        if (s)                 return "R6";
        if (r && m_st != 1)    return "R7";
        if (r)                 return "R3";
        if (l)                 return "R8";
        return "R2";
    endfunction

    // One cycle: drive at negedge, update model, check at next negedge
    task automatic cyc(input bit l, input logic [AW-1:0] la, input bit r,
                       input logic [KW-1:0] k, input bit s,
                       input logic [AW-1:0] sa, input bit f, input string force_tag);
        bit e_go, e_fail;
        logic [KW-1:0] e_key;
        string tag;
        ll_issue = l; ll_addr = la; ll_rsp = r; ll_key = k;
        sc_issue = s; sc_addr = sa; flush = f;
        e_go   = s && !f && (m_st == 2) && (m_addr == sa);
        e_fail = s && !e_go;
        e_key  = m_key;
        tag = (force_tag != "") ? force_tag : pick_tag(l, r, s, f, e_go);
        if (f) m_st = 0;
        else if (l) begin m_st = 1; m_addr = la; end
        else if (s) m_st = 0;
        else if (r && m_st == 1) begin m_st = 2; m_key = k; end
        @(posedge clk);
        @(negedge clk);
        ll_issue = 0; ll_rsp = 0; sc_issue = 0; flush = 0;
        chk(tag, "sc_go", 32'(sc_go), 32'(e_go));
        chk(tag, "sc_lfail", 32'(sc_lfail), 32'(e_fail));
        chk(tag, "resv_valid", 32'(resv_valid), 32'(m_st == 2));
        if (e_go) chk(tag, "sc_key", sc_key, e_key);
    endtask

    task automatic idle1(input string tag);
        cyc(0, '0, 0, '0, 0, '0, 0, tag);
    endtask

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "resv_valid", 32'(resv_valid), 0);
        chk("R1", "sc_go", 32'(sc_go), 0);
        chk("R1", "sc_lfail", 32'(sc_lfail), 0);
        rst_n = 1'b1;
        idle1("R1");

        // R2: pending only, SC fails
        cyc(1, 32'h100, 0, '0, 0, '0, 0, "R2");
        cyc(0, '0, 0, '0, 1, 32'h100, 0, "R2");
        // R3 + R4: full registration then success
        cyc(1, 32'h200, 0, '0, 0, '0, 0, "R2");
        cyc(0, '0, 1, 32'hCAFE0001, 0, '0, 0, "R3");
        cyc(0, '0, 0, '0, 1, 32'h200, 0, "R4");
        // R5: second SC fails
        cyc(0, '0, 0, '0, 1, 32'h200, 0, "R5");
        // R6: mismatched address
        cyc(1, 32'h300, 0, '0, 0, '0, 0, "R6");
        cyc(0, '0, 1, 32'h11, 0, '0, 0, "R6");
        cyc(0, '0, 0, '0, 1, 32'h304, 0, "R6");
        // R7: stray responses ignored (idle, then while held)
        cyc(0, '0, 1, 32'hBAD0, 0, '0, 0, "R7");
        cyc(1, 32'h400, 0, '0, 0, '0, 0, "R7");
        cyc(0, '0, 1, 32'h44, 0, '0, 0, "R7");
        cyc(0, '0, 1, 32'hBAD1, 0, '0, 0, "R7");
        cyc(0, '0, 0, '0, 1, 32'h400, 0, "R7");
        // R8: overwrite
        cyc(1, 32'h500, 0, '0, 0, '0, 0, "R8");
        cyc(0, '0, 1, 32'h55, 0, '0, 0, "R8");
        cyc(1, 32'h600, 0, '0, 0, '0, 0, "R8");
        cyc(0, '0, 1, 32'h66, 0, '0, 0, "R8");
        cyc(0, '0, 0, '0, 1, 32'h500, 0, "R8");
        cyc(1, 32'h600, 0, '0, 0, '0, 0, "R8");
        cyc(0, '0, 1, 32'h67, 0, '0, 0, "R8");
        cyc(0, '0, 0, '0, 1, 32'h600, 0, "R8");
        // R9: flush alone, and flush with SC
        cyc(1, 32'h700, 0, '0, 0, '0, 0, "R9");
        cyc(0, '0, 1, 32'h77, 0, '0, 0, "R9");
        cyc(0, '0, 0, '0, 0, '0, 1, "R9");
        cyc(0, '0, 0, '0, 1, 32'h700, 0, "R9");
        cyc(1, 32'h710, 0, '0, 0, '0, 0, "R9");
        cyc(0, '0, 1, 32'h78, 0, '0, 0, "R9");
        cyc(0, '0, 0, '0, 1, 32'h710, 1, "R9");
        // R10: SC with LL, judged on old reservation
        cyc(1, 32'h800, 0, '0, 0, '0, 0, "R10");
        cyc(0, '0, 1, 32'h88, 0, '0, 0, "R10");
        cyc(1, 32'h900, 0, '0, 1, 32'h800, 0, "R10");
        cyc(0, '0, 1, 32'h99, 0, '0, 0, "R10");
        cyc(0, '0, 0, '0, 1, 32'h900, 0, "R10");
        // R11: SC with the completing response
        cyc(1, 32'hA00, 0, '0, 0, '0, 0, "R11");
        cyc(0, '0, 1, 32'hAA, 1, 32'hA00, 0, "R11");
        cyc(0, '0, 1, 32'hAB, 0, '0, 0, "R11");
        cyc(0, '0, 0, '0, 1, 32'hA00, 0, "R11");

        // Random traffic over a small address set
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a1, a2;
            a1 = 32'h40 * ($urandom % 3);
            a2 = 32'h40 * ($urandom % 3);
            cyc(($urandom % 5) == 0, a1, ($urandom % 3) == 0, $urandom,
                ($urandom % 4) == 0, a2, ($urandom % 23) == 0, "");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule